// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital control core of a four-channel simultaneous-sampling converter. A rising edge on the start input captures all four channel sample words in one cycle. The block then works through the enabled channels one after another, spending a fixed, parameterised number of clock cycles on each conversion, and stores every result in a result slot for readout. The analog front end and the successive-approximation core are outside the block. Sample words arrive as digital inputs, and a cycle counter stands in for the conversion time.

The enabled channel subset comes from one of two sources. A mode input picks either four select pins or an internal 4-bit select register, which is written over the low data lines by a chip-select plus write-strobe cycle. The subset is frozen at the accepted start edge. `busy_o` covers the whole sequence and `eoc_o` pulses once per finished channel. Results are read over a 12-bit bus with chip-select and read-strobe. They can be read after `busy_o` falls or one at a time after each `eoc_o` pulse. An internal read pointer steps through the results in conversion order.

Top module: `adc_seq_top`

## Requirements
- R1: At the clock edge where a start rising edge is accepted, all four sample words are held. Changes on `sample_i` after that edge do not alter the results of that sequence.
- R2: When `hw_sel_i`=0 the enabled set is `ch_sel_i`. When it is 1 the enabled set is the select register. Bit i enables channel i+1, and channel i+1 occupies `sample_i[12*i +: 12]`.
- R3: While `cs_ni` and `wr_ni` are both low at a clock edge, the select register loads `data_i[3:0]`.
- R4: The enabled set is latched at the accepted start edge. Changes to `ch_sel_i`, `hw_sel_i` or the select register during a sequence do not affect that sequence.
- R5: `busy_o` rises at the clock edge that samples the start rising edge. It stays high for exactly N*CONV_CYCLES cycles, where N is the number of enabled channels. `track_o` is the inverse of `busy_o`.
- R6: `eoc_o` is a one-cycle pulse after each conversion, giving N pulses per sequence. The last pulse starts in the same cycle that `busy_o` falls.
- R7: Enabled channels are converted in ascending order. The read pointer clears at each accepted start and advances at the end of each read strobe. Read k of a sequence returns the k-th converted result.
- R8: `data_oe_o` is high only while `cs_ni` and `rd_ni` are both low. In that case `data_o` shows the result at the read pointer; otherwise `data_o` is 0.
- R9: A start rising edge while `busy_o` is high is ignored. It has no effect on timing, results or the read pointer.
- R10: With an empty enabled set, `busy_o` is high for one cycle and no `eoc_o` pulse occurs.
- R11: After reset, `busy_o`=0, `eoc_o`=0, `track_o`=1 and `data_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion start; the rising edge is used |
| hw_sel_i | input | 1 | Subset source: 0 pins, 1 register |
| ch_sel_i | input | 4 | Channel enable pins |
| sample_i | input | 48 | Four 12-bit sample words |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_i | input | 12 | Write data; bits 3:0 load the select register |
| data_o | output | 12 | Read data |
| data_oe_o | output | 1 | Read data drive enable |
| busy_o | output | 1 | Sequence in progress |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |
| track_o | output | 1 | Sample stage tracking |

## Verification
The hardest situation to reach from the ports is a sequence that is disturbed while it runs. In that case the pins, the mode input, the select register, the samples and a second start edge all change mid-sequence, yet the results, timing and read order must match what was latched at the accepted edge. Each trial does this. After the start, it overwrites every selection source with fresh random values, writes the register and, in chosen trials, pulses start again, sometimes while reading results one per `eoc_o`. Partial read-outs leave the pointer mid-way, so the next trial's first read shows whether the pointer cleared at its start.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic {ST_IDLE, ST_CONV} seq_state_e;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned CONV_CYCLES = 8,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic              cap_o,
  output logic              busy_o,
  output logic              eoc_o,
  output logic              done_o,
  output logic [CH_W-1:0]   done_ch_o,
  output logic [CH_W-1:0]   done_slot_o
);
  seq_state_e        state_q;
  logic              start_q, start_rise, eoc_q;
  logic [NUM_CH-1:0] remain_q, lat_mask_q, remain_next;
  logic [CNT_W-1:0]  cnt_q;
  logic [CH_W-1:0]   slot_q, cur_ch;

  assign start_rise = start_i & ~start_q;
  assign busy_o     = (state_q == ST_CONV);
  assign cap_o      = start_rise & ~busy_o;

  // lowest pending channel converts next
  always_comb begin
    cur_ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (remain_q[i]) cur_ch = CH_W'(i);
    end
  end

  assign remain_next = remain_q & ~(NUM_CH'(1) << cur_ch);
  assign done_o      = busy_o && (remain_q != '0) && (cnt_q == CNT_W'(CONV_CYCLES - 1));
  assign done_ch_o   = cur_ch;
  assign done_slot_o = slot_q;
  assign eoc_o       = eoc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q    <= 1'b0;
      state_q    <= ST_IDLE;
      remain_q   <= '0;
      lat_mask_q <= '0;
      cnt_q      <= '0;
      slot_q     <= '0;
      eoc_q      <= 1'b0;
    end else begin
      start_q <= start_i;
      eoc_q   <= done_o;
      if (cap_o) begin
        state_q    <= ST_CONV;
        remain_q   <= mask_i;
        lat_mask_q <= mask_i;
        cnt_q      <= '0;
        slot_q     <= '0;
      end else if (busy_o) begin
        if (remain_q == '0) begin
          state_q <= ST_IDLE;
        end else if (done_o) begin
          cnt_q    <= '0;
          remain_q <= remain_next;
          slot_q   <= slot_q + 1'b1;
          if (remain_next == '0) state_q <= ST_IDLE;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_rise)); // R5
  AST_EOC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o); // R6
  AST_EOC_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && lat_mask_q != '0) |-> eoc_o); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_rise) |=> $stable(lat_mask_q)); // R9
  AST_EMPTY_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && lat_mask_q == '0) |=> !busy_o); // R10
endmodule

// File: rtl/adc_seq_store.sv
module adc_seq_store #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 12,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cap_i,
  input  logic [NUM_CH*DATA_W-1:0] sample_i,
  input  logic                     done_i,
  input  logic [CH_W-1:0]          done_ch_i,
  input  logic [CH_W-1:0]          done_slot_i,
  input  logic [CH_W-1:0]          rd_idx_i,
  output logic [DATA_W-1:0]        rd_data_o
);
  logic [DATA_W-1:0] hold_q [NUM_CH];
  logic [DATA_W-1:0] res_q  [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q[g] <= '0;
        res_q[g]  <= '0;
      end else begin
        if (cap_i) hold_q[g] <= sample_i[g*DATA_W +: DATA_W];
        if (done_i && done_slot_i == CH_W'(g)) res_q[g] <= hold_q[done_ch_i];
      end
    end
  end

  assign rd_data_o = res_q[rd_idx_i];

  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(hold_q[0])); // R1
endmodule

// File: rtl/adc_seq_bus.sv
module adc_seq_bus #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 12,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cap_i,
  output logic [NUM_CH-1:0] sel_reg_o,
  output logic [CH_W-1:0]   rd_ptr_o,
  output logic              rd_act_o
);
  logic            rd_act_q, wr_act;
  logic [CH_W-1:0] ptr_q;

  assign rd_act_o = ~cs_ni & ~rd_ni;
  assign wr_act   = ~cs_ni & ~wr_ni;
  assign rd_ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act_q  <= 1'b0;
      ptr_q     <= '0;
      sel_reg_o <= '0;
    end else begin
      rd_act_q <= rd_act_o;
      if (wr_act) sel_reg_o <= data_i[NUM_CH-1:0];
      if (cap_i) ptr_q <= '0;
      else if (rd_act_q && !rd_act_o)
        ptr_q <= (ptr_q == CH_W'(NUM_CH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  AST_SEL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_act |=> sel_reg_o == $past(data_i[NUM_CH-1:0])); // R3
  AST_PTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> ptr_q == '0); // R7
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned CONV_CYCLES = 8,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     hw_sel_i,
  input  logic [NUM_CH-1:0]        ch_sel_i,
  input  logic [NUM_CH*DATA_W-1:0] sample_i,
  input  logic                     cs_ni,
  input  logic                     rd_ni,
  input  logic                     wr_ni,
  input  logic [DATA_W-1:0]        data_i,
  output logic [DATA_W-1:0]        data_o,
  output logic                     data_oe_o,
  output logic                     busy_o,
  output logic                     eoc_o,
  output logic                     track_o
);
  logic              cap, done, rd_act;
  logic [CH_W-1:0]   done_ch, done_slot, rd_ptr;
  logic [NUM_CH-1:0] sel_reg, mask;
  logic [DATA_W-1:0] rd_data;

  assign mask = hw_sel_i ? sel_reg : ch_sel_i;

  adc_seq_ctrl #(.NUM_CH(NUM_CH), .CONV_CYCLES(CONV_CYCLES)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .mask_i(mask), .cap_o(cap), .busy_o, .eoc_o,
    .done_o(done), .done_ch_o(done_ch), .done_slot_o(done_slot)
  );

  adc_seq_store #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_store (
    .clk_i, .rst_ni, .cap_i(cap), .sample_i, .done_i(done), .done_ch_i(done_ch),
    .done_slot_i(done_slot), .rd_idx_i(rd_ptr), .rd_data_o(rd_data)
  );

  adc_seq_bus #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_bus (
    .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni, .data_i, .cap_i(cap),
    .sel_reg_o(sel_reg), .rd_ptr_o(rd_ptr), .rd_act_o(rd_act)
  );

  assign data_oe_o = rd_act;
  assign data_o    = rd_act ? rd_data : '0;
  assign track_o   = ~busy_o;

  AST_OE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!cs_ni && !rd_ni)); // R8
endmodule

// File: tb/test_adc_seq_top.sv
module test_adc_seq_top;
  localparam int C = 8;
  logic clk = 0, rst_ni = 0;
  logic start = 0, hw_sel = 0, cs_n = 1, rd_n = 1, wr_n = 1;
  logic [3:0] ch_sel = 0;
  logic [47:0] sample = 0;
  logic [11:0] data_in = 0, data_out;
  logic oe, busy, eoc, track;
  int checks = 0, errors = 0;
  int busy_tot = 0, eoc_tot = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_seq_top #(.NUM_CH(4), .DATA_W(12), .CONV_CYCLES(C)) i_adc_seq_top (
    .clk_i(clk), .rst_ni, .start_i(start), .hw_sel_i(hw_sel), .ch_sel_i(ch_sel),
    .sample_i(sample), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n), .data_i(data_in),
    .data_o(data_out), .data_oe_o(oe), .busy_o(busy), .eoc_o(eoc), .track_o(track)
  );

  always @(negedge clk) begin
    if (busy) busy_tot++;
    if (eoc) eoc_tot++;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int n_sel(logic [3:0] m);
    int n = 0;
    for (int i = 0; i < 4; i++) n += m[i];
    return n;
  endfunction

  task automatic wr_reg(logic [3:0] v);
    @(negedge clk); cs_n = 0; wr_n = 0; data_in = {$urandom_range(255, 0), v};
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic rd_word(output logic [11:0] v, output logic o);
    @(negedge clk); cs_n = 0; rd_n = 0;
    #1; v = data_out; o = oe;
    @(negedge clk); cs_n = 1; rd_n = 1;
    #1;
    check(oe == 0 && data_out == 0, "R8 idle bus", data_out, 0);
  endtask

  task automatic trial(bit mode, logic [3:0] m, bit per_eoc, bit restart, bit partial);
    logic [11:0] smp[4], exp_res[4], v;
    logic o;
    int n = n_sel(m), k = 0, b0, e0;
    for (int i = 0; i < 4; i++) if (m[i]) begin exp_res[k] = 12'($urandom); k++; end
    k = 0;
    for (int i = 0; i < 4; i++) smp[i] = 12'($urandom);
    for (int i = 0; i < 4; i++) if (m[i]) begin exp_res[k] = smp[i]; k++; end
    if (mode) begin wr_reg(m); ch_sel = ~m; end
    else begin wr_reg(~m); ch_sel = m; end
    @(negedge clk);
    hw_sel = mode;
    for (int i = 0; i < 4; i++) sample[i*12 +: 12] = smp[i];
    b0 = busy_tot; e0 = eoc_tot;
    start = 1;
    @(negedge clk); start = 0;
    check(busy == 1 && track == 0, "R5 busy rise", busy, 1);
    // disturb every source while converting (R1, R4)
    sample = {$urandom, $urandom};
    ch_sel = 4'($urandom); hw_sel = ~mode;
    if (n > 0) wr_reg(4'($urandom));
    if (restart && n > 0) begin
      @(negedge clk); start = 1; @(negedge clk); start = 0;
    end
    if (per_eoc) begin
      for (int r = 0; r < n; r++) begin
        while (eoc_tot - e0 <= r) @(negedge clk);
        rd_word(v, o);
        check(o == 1 && v == exp_res[r], "R7 read per eoc", v, exp_res[r]);
      end
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check(busy_tot - b0 == ((n == 0) ? 1 : n * C), (n == 0) ? "R10 empty busy" : "R5 busy length",
          busy_tot - b0, (n == 0) ? 1 : n * C);
    check(eoc_tot - e0 == n, (n == 0) ? "R10 no eoc" : "R6 eoc count", eoc_tot - e0, n);
    check(track == 1, "R5 track", track, 1);
    if (!per_eoc) begin
      int nr = partial ? (n + 1) / 2 : n;
      for (int r = 0; r < nr; r++) begin
        rd_word(v, o);
        check(o == 1 && v == exp_res[r],
              mode ? "R2 R3 R4 R1 R7 register set" : "R2 R4 R1 R7 pin set", v, exp_res[r]);
      end
    end
    if (restart) check(1, "R9 restart ignored", 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B));
    repeat (3) @(negedge clk);
    check(busy == 0 && eoc == 0 && track == 1 && oe == 0, "R11 reset", busy, 0);
    rst_ni = 1;
    @(negedge clk);
    check(busy == 0 && track == 1 && oe == 0, "R11 after release", busy, 0);
    trial(0, 4'b1111, 0, 0, 0);
    trial(1, 4'b0000, 0, 0, 0);
    trial(1, 4'b1000, 0, 1, 0);
    trial(0, 4'b0101, 1, 1, 0);
    trial(1, 4'b1110, 0, 0, 1);
    trial(0, 4'b0001, 0, 0, 0);
    for (int t = 0; t < 40; t++)
      trial(1'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule